// File: doc/BRIEF.md
# Branch History Table Direction Predictor

This block guesses, in the fetch stage, whether a conditional branch will be taken. It keeps a table of prediction entries. The table is selected by the low-order bits of the fetch PC, after the byte-offset bits are dropped. A parameter selects one of two entry policies. The first is a single bit that remembers the last outcome. The second is a 2-bit saturating counter that only changes its guess after repeated contrary outcomes. The guess is captured into the IF/ID pipeline register together with the table index, so decode receives both alongside the instruction.

When decode resolves a branch, it sends the resolved direction back on the update port. With it go the entry index and the guess that travelled with that instruction. The block trains the entry and raises a mispredict pulse when the resolved direction disagrees with the carried guess. Entries carry no tags, so unrelated branches whose PCs share the low bits share an entry. This costs accuracy only, never correctness. Target caching and the flush itself are handled elsewhere.

Top module: `bht_predictor`

## Requirements
- R1: The entry index is `fetch_pc[OFFSET_BITS +: log2(ENTRIES)]`. The defaults are ENTRIES = 4096 and OFFSET_BITS = 2.
- R2: A fetch with `fetch_valid` high at a clock edge appears after that edge on `id_valid` (high), `id_pred_taken` and `id_index`. A cycle without fetch leaves `id_valid` low after the edge.
- R3: Reset sets every entry to INIT_STATE and clears `id_valid`. The default INIT_STATE is 01, which predicts not taken. In 1-bit mode the initial bit is INIT_STATE bit 1.
- R4: In 1-bit mode (POLICY = last outcome), an update stores the resolved direction. A mispredicted update therefore inverts the stored bit, and a correctly predicted update leaves it unchanged.
- R5: In 2-bit mode the prediction is the upper counter bit. States 11 and 10 predict taken (1); states 01 and 00 predict not taken (0).
- R6: In 2-bit mode, a taken update increments the counter and saturates at 11. A not-taken update decrements it and saturates at 00.
- R7: In 2-bit mode, a strong state changes its prediction only after two consecutive contrary outcomes. A loop branch taken nine times then not taken therefore mispredicts once per later pass; in 1-bit mode it mispredicts twice.
- R8: `mispredict` is high in the same cycle as an update with `upd_valid` high whose `upd_taken` differs from `upd_pred_taken`. It is low otherwise, whatever the entry currently holds.
- R9: PCs that differ only in bits above the index share one entry. Training through one PC changes the prediction seen through the other.
- R10: When a lookup and an update use the same index in one cycle, the lookup returns the value the entry held before the update.
- R11: With `upd_valid` low, the update inputs change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch occurs this cycle |
| fetch_pc | input | PC_W | Fetch address |
| id_valid | output | 1 | IF/ID holds a fetched prediction |
| id_pred_taken | output | 1 | Predicted direction carried to decode (1 = taken) |
| id_index | output | log2(ENTRIES) | Table index carried to decode |
| upd_valid | input | 1 | A branch is resolved this cycle |
| upd_index | input | log2(ENTRIES) | Index of the resolved branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |
| upd_pred_taken | input | 1 | Prediction that travelled with the resolved branch |
| mispredict | output | 1 | Resolved direction disagrees with carried prediction |

## Verification
Every cycle, the assertions check that the IF/ID capture follows the fetch, that the captured index is the addressed PC slice, that reset empties the register, and that a mispredict never appears without an update. The table contents are only visible through later fetches, so only the bench's scenarios can show the training rules. These scenarios cover counter saturation, the hysteresis in loop passes, the single-bit inversion, aliasing through higher PC bits, the old value on a lookup that collides with an update, and the absence of training on invalid updates.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    typedef enum logic {
        POLICY_LAST = 1'b0,
        POLICY_HYST = 1'b1
    } policy_e;

    // Saturating up/down step of a hysteresis counter.
    function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic ctr_predict(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bht_index_calc.sv
module bht_index_calc #(
    parameter int PC_W        = 32,
    parameter int OFFSET_BITS = 2,
    parameter int IDX_W       = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    logic unused_pc_bits;

    assign idx            = pc[OFFSET_BITS +: IDX_W];
    assign unused_pc_bits = ^pc;
endmodule

// File: rtl/bht_state_table.sv
module bht_state_table
    import bht_pkg::*;
#(
    parameter int      ENTRIES    = 4096,
    parameter int      IDX_W      = 12,
    parameter policy_e POLICY     = POLICY_HYST,
    parameter ctr_t    INIT_STATE = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_pred,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    generate
        if (POLICY == POLICY_HYST) begin : g_hyst
            ctr_t cells [ENTRIES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < ENTRIES; i++)
                        cells[i] <= INIT_STATE;
                end else if (wr_en) begin
                    cells[wr_idx] <= ctr_next(cells[wr_idx], wr_taken);
                end
            end

            assign rd_pred = ctr_predict(cells[rd_idx]);
        end else begin : g_last
            logic cells [ENTRIES];

            // Storing the outcome flips the bit exactly when it was wrong.
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < ENTRIES; i++)
                        cells[i] <= INIT_STATE[1];
                end else if (wr_en) begin
                    cells[wr_idx] <= wr_taken;
                end
            end

            assign rd_pred = cells[rd_idx];
        end
    endgenerate
endmodule

// File: rtl/bht_ifid_stage.sv
module bht_ifid_stage #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_pred,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    output logic             out_pred,
    output logic [IDX_W-1:0] out_idx
);
    typedef struct packed {
        logic             valid;
        logic             pred;
        logic [IDX_W-1:0] idx;
    } ifid_t;

    ifid_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q.valid <= in_valid;
            slot_q.pred  <= in_pred;
            slot_q.idx   <= in_idx;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_pred  = slot_q.pred;
    assign out_idx   = slot_q.idx;
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int      ENTRIES     = 4096,
    parameter int      PC_W        = 32,
    parameter int      OFFSET_BITS = 2,
    parameter policy_e POLICY      = POLICY_HYST,
    parameter ctr_t    INIT_STATE  = CTR_WEAK_NT,
    localparam int     IDX_W       = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             id_valid,
    output logic             id_pred_taken,
    output logic [IDX_W-1:0] id_index,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             upd_taken,
    input  logic             upd_pred_taken,
    output logic             mispredict
);
    logic [IDX_W-1:0] look_idx;
    logic             look_pred;

    bht_index_calc #(
        .PC_W(PC_W), .OFFSET_BITS(OFFSET_BITS), .IDX_W(IDX_W)
    ) u_index (
        .pc (fetch_pc),
        .idx(look_idx)
    );

    bht_state_table #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .POLICY(POLICY), .INIT_STATE(INIT_STATE)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_pred (look_pred),
        .wr_en   (upd_valid),
        .wr_idx  (upd_index),
        .wr_taken(upd_taken)
    );

    bht_ifid_stage #(.IDX_W(IDX_W)) u_ifid (
        .clk      (clk),
        .rst      (rst),
        .in_valid (fetch_valid),
        .in_pred  (look_pred),
        .in_idx   (look_idx),
        .out_valid(id_valid),
        .out_pred (id_pred_taken),
        .out_idx  (id_index)
    );

    assign mispredict = upd_valid & (upd_taken ^ upd_pred_taken);
endmodule

// File: rtl/bht_predictor_checker.sv
module bht_predictor_checker #(
    parameter int PC_W        = 32,
    parameter int OFFSET_BITS = 2,
    parameter int IDX_W       = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_valid,
    input logic [PC_W-1:0]  fetch_pc,
    input logic             id_valid,
    input logic [IDX_W-1:0] id_index,
    input logic             upd_valid,
    input logic             mispredict
);
    assert_no_valid_after_reset_R3: assert property (@(posedge clk)
        rst |=> !id_valid);

    assert_fetch_captured_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> id_valid);

    assert_idle_fetch_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> !id_valid);

    assert_index_from_pc_R1: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> (id_index == $past(fetch_pc[OFFSET_BITS +: IDX_W])));

    assert_miss_needs_update_R8: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> upd_valid);
endmodule

bind bht_predictor bht_predictor_checker #(
    .PC_W(PC_W), .OFFSET_BITS(OFFSET_BITS), .IDX_W(IDX_W)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .fetch_valid(fetch_valid),
    .fetch_pc   (fetch_pc),
    .id_valid   (id_valid),
    .id_index   (id_index),
    .upd_valid  (upd_valid),
    .mispredict (mispredict)
);

// File: tb/bht_predictor_bench.sv
`timescale 1ns/1ps
module bht_predictor_bench;
    import bht_pkg::*;

    localparam int ENT = 16;
    localparam int PCW = 32;
    localparam int OFS = 2;
    localparam int IW  = $clog2(ENT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic           fetch_valid = 1'b0;
    logic [PCW-1:0] fetch_pc    = '0;
    logic           upd_valid   = 1'b0;
    logic [IW-1:0]  upd_index   = '0;
    logic           upd_taken   = 1'b0;
    logic           upd_pred_h  = 1'b0;
    logic           upd_pred_l  = 1'b0;

    logic          id_valid_h, id_pred_h, miss_h;
    logic          id_valid_l, id_pred_l, miss_l;
    logic [IW-1:0] id_index_h, id_index_l;

    bht_predictor #(.ENTRIES(ENT), .PC_W(PCW), .OFFSET_BITS(OFS), .POLICY(POLICY_HYST))
    u_bht_predictor (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .id_valid(id_valid_h), .id_pred_taken(id_pred_h), .id_index(id_index_h),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
        .upd_pred_taken(upd_pred_h), .mispredict(miss_h)
    );

    bht_predictor #(.ENTRIES(ENT), .PC_W(PCW), .OFFSET_BITS(OFS), .POLICY(POLICY_LAST))
    u_bht_predictor_onebit (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .id_valid(id_valid_l), .id_pred_taken(id_pred_l), .id_index(id_index_l),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
        .upd_pred_taken(upd_pred_l), .mispredict(miss_l)
    );

    int checks = 0;
    int errors = 0;
    int miss_cnt_h = 0;
    int miss_cnt_l = 0;

    typedef struct {
        logic          pred_h;
        logic          pred_l;
        logic [IW-1:0] idx;
        string         req;
    } exp_t;

    exp_t q[$];
    ctr_t m_h [ENT];
    logic m_l [ENT];

    function automatic void chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // Driver: one cycle of fetch and/or update; force_pred < 0 uses the model's guess.
    task automatic step(input logic fv, input logic [PCW-1:0] pc, input logic uv,
                        input logic [IW-1:0] ui, input logic ut, input int force_pred,
                        input string req);
        exp_t e;
        logic [IW-1:0] fi;
        @(negedge clk);
        fi = pc[OFS +: IW];
        fetch_valid = fv;
        fetch_pc    = pc;
        upd_valid   = uv;
        upd_index   = ui;
        upd_taken   = ut;
        upd_pred_h  = (force_pred < 0) ? m_h[ui][1] : force_pred[0];
        upd_pred_l  = (force_pred < 0) ? m_l[ui]    : force_pred[0];
        if (fv) begin
            e.pred_h = m_h[fi][1];   // old value on a colliding update (R10)
            e.pred_l = m_l[fi];
            e.idx    = fi;
            e.req    = req;
            q.push_back(e);
        end
        #1;
        chk("R8 mispredict 2-bit", int'(miss_h), int'(uv && (ut != upd_pred_h)));
        chk("R8 mispredict 1-bit", int'(miss_l), int'(uv && (ut != upd_pred_l)));
        if (miss_h) miss_cnt_h++;
        if (miss_l) miss_cnt_l++;
        if (uv) begin
            if (ut) m_h[ui] = (m_h[ui] == 2'b11) ? 2'b11 : m_h[ui] + 2'd1;
            else    m_h[ui] = (m_h[ui] == 2'b00) ? 2'b00 : m_h[ui] - 2'd1;
            m_l[ui] = ut;
        end
    endtask

    task automatic fetch(input logic [PCW-1:0] pc, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, -1, req);
    endtask

    task automatic train(input logic [IW-1:0] ui, input logic ut, input string req);
        step(1'b0, '0, 1'b1, ui, ut, -1, req);
    endtask

    // Monitor: pops expected predictions as IF/ID presents them.
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            chk("R2 valid equal across modes", int'(id_valid_l), int'(id_valid_h));
            if (id_valid_h) begin
                if (q.size() == 0) begin
                    chk("R2 unexpected id_valid", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk({e.req, " pred 2-bit"}, int'(id_pred_h), int'(e.pred_h));
                    chk({e.req, " pred 1-bit"}, int'(id_pred_l), int'(e.pred_l));
                    chk("R1 index", int'(id_index_h), int'(e.idx));
                end
            end
        end
    end

    task automatic run_all();
        for (int i = 0; i < ENT; i++) begin
            m_h[i] = 2'b01;
            m_l[i] = 1'b0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 id_valid in reset", int'(id_valid_h), 0);
        chk("R3 mispredict in reset", int'(miss_h), 0);
        rst = 1'b0;

        for (int i = 0; i < ENT; i++) fetch(PCW'(i * 4), "R3 initial weak not taken");

        // R5/R6: climb to strong taken, then saturate at 11
        for (int i = 0; i < 4; i++) begin
            train(4'd3, 1'b1, "R6 increment");
            fetch(32'h0000_000C, "R5 R6 after taken update");
        end
        // R7: strong taken holds after one contrary outcome
        train(4'd3, 1'b0, "R7 first contrary");
        fetch(32'h0000_000C, "R7 still taken after one not-taken");
        train(4'd3, 1'b0, "R7 second contrary");
        fetch(32'h0000_000C, "R7 flips after two not-taken");
        for (int i = 0; i < 3; i++) begin
            train(4'd3, 1'b0, "R6 decrement");
            fetch(32'h0000_000C, "R6 saturate at 00");
        end
        train(4'd3, 1'b1, "R6 up from 00");
        fetch(32'h0000_000C, "R6 01 still not taken");

        // R7 / R4: loop branch, nine taken then exit
        for (int pass = 0; pass < 3; pass++) begin
            if (pass == 2) begin
                miss_cnt_h = 0;
                miss_cnt_l = 0;
            end
            for (int it = 0; it < 10; it++) begin
                fetch(32'h0000_0014, "R7 R4 loop lookup");
                train(4'd5, (it < 9), "R7 R4 loop resolve");
            end
        end
        chk("R7 loop pass mispredicts 2-bit", miss_cnt_h, 1);
        chk("R4 loop pass mispredicts 1-bit", miss_cnt_l, 2);

        // R4: single-bit inversion on a miss, hold on a hit
        train(4'd9, 1'b1, "R4 invert on miss");
        fetch(32'h0000_0024, "R4 bit now taken");
        train(4'd9, 1'b1, "R4 correct keeps bit");
        fetch(32'h0000_0024, "R4 bit kept");
        train(4'd9, 1'b0, "R4 invert back");
        fetch(32'h0000_0024, "R4 bit inverted back");

        // R9: aliasing through higher PC bits
        train(4'd6, 1'b1, "R9 train via 0x18");
        train(4'd6, 1'b1, "R9 train via 0x18");
        fetch(32'h0000_0058, "R9 alias 0x58 sees taken");
        fetch(32'h0000_1018, "R9 alias 0x1018 sees taken");
        fetch(32'h0000_001C, "R9 neighbour untouched");

        // R10: lookup and update of one index in the same cycle
        step(1'b1, 32'h0000_001C, 1'b1, 4'd7, 1'b1, -1, "R10 same cycle");
        step(1'b1, 32'h0000_001C, 1'b1, 4'd7, 1'b1, -1, "R10 same cycle second");
        fetch(32'h0000_001C, "R10 new value visible");

        // R11: invalid updates do not train
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 4'd8, 1'b1, -1, "R11 idle");
        fetch(32'h0000_0020, "R11 entry untouched");

        // R8: carried prediction decides, not the table contents
        step(1'b0, '0, 1'b1, 4'd10, 1'b1, 1, "R8 carried taken");
        step(1'b0, '0, 1'b1, 4'd11, 1'b0, 1, "R8 carried taken resolved not");
        step(1'b0, '0, 1'b0, 4'd12, 1'b1, 0, "R8 no update no miss");

        repeat (3) step(1'b0, '0, 1'b0, '0, 1'b0, -1, "drain");
        chk("R2 all predictions delivered", q.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule